// File: doc/BRIEF.md
# Write-Once Flash Timing Divider

This block holds one 8-bit configuration word for a flash controller. From the bus clock it produces the program/erase timing base. The word has three fields. Bit 7 is a sticky "configured" flag. Bit 6 switches in a fixed divide-by-8 prescaler. Bits 5:0 hold a divisor N. The timing base is a one-bus-cycle enable pulse, `tick`. It repeats every N+1 bus cycles with the prescaler off and every 8·(N+1) bus cycles with it on. One period of `tick` is the unit that a program/erase sequencer counts. For example, a 10 MHz bus with the prescaler off and N = 49 gives 200 kHz. A 20 MHz bus with the prescaler on and N = 12 gives about 192.3 kHz.

Software reaches the word through a single-address port: `sel` is the address decode, `wr_en` is the write strobe, and `rdata` always shows the whole word. In normal operation the word can be written once after reset. That first write sets the configured flag whatever its bit 7 holds, and it raises `pe_enable`, which permits program and erase. Later writes are dropped. When `test_mode` is high and `flash_done` is 1, every bit can be rewritten, including the flag. When `test_mode` is high and `flash_done` is 0, nothing can be written.

The load flag is kept by a two-state machine. State `ST_BLANK` means not configured and state `ST_LOCKED` means configured. The transitions are:
- BLANK→LOCKED on a normal-mode write.
- LOCKED→LOCKED when a normal-mode write is ignored.
- Either state→LOCKED on a test write with bit 7 = 1.
- Either state→BLANK on a test write with bit 7 = 0.
- Reset always returns to BLANK.

Both counters are held at zero in BLANK. They restart from zero on every accepted write.

Top module: `flash_tick_gen`

## Requirements
- R1: After reset `rdata` is 0x00, `pe_enable` is 0 and `tick` is 0.
- R2: The first normal-mode write (`test_mode`=0, `sel`=1, `wr_en`=1) stores `wdata[6:0]` and sets `rdata[7]` to 1, whatever `wdata[7]` is. `pe_enable` is 1 from the next cycle.
- R3: Once `rdata[7]` is 1, normal-mode writes change neither `rdata` nor the phase of `tick`.
- R4: A write with `sel`=0 has no effect.
- R5: A write with `test_mode`=1 and `flash_done`=1 loads all eight bits of `wdata` as given. Bit 7 = 0 clears the flag and `pe_enable`.
- R6: A write with `test_mode`=1 and `flash_done`=0 is ignored.
- R7: With bit 6 = 0 and divisor N, the first `tick` comes in the (N+1)-th cycle after the accepted write's clock edge, and ticks repeat every N+1 cycles.
- R8: With bit 6 = 1 and divisor N, the first `tick` comes 8·(N+1) cycles after the write, and ticks repeat at that period.
- R9: With bit 6 = 0 and N = 0, `tick` is high in every cycle.
- R10: While `rdata[7]` is 0, `tick` stays low. A normal-mode write that follows a test-mode clear is accepted again, and timing restarts from zero.
- R11: `rdata` shows all eight bits in either mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel | input | 1 | Address decode hit for the configuration word |
| wr_en | input | 1 | Write strobe |
| wdata | input | 8 | Write data |
| test_mode | input | 1 | Selects test-mode write rules |
| flash_done | input | 1 | Flash idle flag; gates test-mode writes |
| rdata | output | 8 | Configuration word read-back |
| tick | output | 1 | One-cycle timing-base pulse |
| pe_enable | output | 1 | Program/erase permitted |

## Verification
Most faults in the load-flag state machine appear on `rdata[7]` and `pe_enable` in the cycle after the offending write. This covers a flag that fails to set, a lock that lets a second write through, and a test write that slips past `flash_done`=0. A divider or prescaler count that is off by one is visible in the first `tick` after a write, so it shows within one programmed period. A restart on a write that should have been ignored is caught by writing a few cycles into a period and checking that the next `tick` keeps its original phase.

// File: rtl/fcd_pkg.sv
package fcd_pkg;
    typedef enum logic {
        ST_BLANK  = 1'b0,
        ST_LOCKED = 1'b1
    } ld_state_e;
endpackage

// File: rtl/fcd_cfg_reg.sv
module fcd_cfg_reg #(
    parameter int unsigned DIV_W = 6,
    localparam int unsigned WORD_W = DIV_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic              test_mode,
    input  logic              flash_done,
    input  logic [WORD_W-1:0] wdata,
    output logic              loaded,
    output logic              pre8,
    output logic [DIV_W-1:0]  divisor,
    output logic              restart
);
    import fcd_pkg::*;

    ld_state_e state_q, state_d;
    logic      wr_test, wr_user;

    assign wr_test = wr_stb && test_mode && flash_done;
    assign wr_user = wr_stb && !test_mode && (state_q == ST_BLANK);
    assign restart = wr_test || wr_user;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_BLANK:  if (wr_user) state_d = ST_LOCKED;
            ST_LOCKED: state_d = ST_LOCKED;
        endcase
        if (wr_test) state_d = wdata[WORD_W-1] ? ST_LOCKED : ST_BLANK;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_BLANK;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre8    <= 1'b0;
            divisor <= '0;
        end else if (restart) begin
            pre8    <= wdata[DIV_W];
            divisor <= wdata[DIV_W-1:0];
        end
    end

    assign loaded = (state_q == ST_LOCKED);

    // R2: a normal-mode write in BLANK always lands in LOCKED
    a_r2_first_write_locks: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && !test_mode && !loaded) |=> loaded);
    // R3: the configuration is frozen against normal-mode writes once locked
    a_r3_locked_stays: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && !test_mode && loaded) |=> (loaded && $stable(pre8) && $stable(divisor)));
    // R6: a test write without flash_done leaves every bit alone
    a_r6_test_needs_done: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && test_mode && !flash_done) |=> ($stable(loaded) && $stable(pre8) && $stable(divisor)));
endmodule

// File: rtl/fcd_prescale.sv
module fcd_prescale #(
    parameter int unsigned PRE_LOG2 = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hold,
    input  logic enable,
    output logic pre_tick
);
    logic [PRE_LOG2-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       cnt_q <= '0;
        else if (hold)    cnt_q <= '0;
        else if (enable)  cnt_q <= cnt_q + 1'b1;
        else              cnt_q <= '0;
    end

    assign pre_tick = enable ? (&cnt_q) : 1'b1;

    // R8: with the prescaler on, a strobe is never followed by another strobe
    a_r8_prescale_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && pre_tick && !hold) |=> !pre_tick || !enable);
endmodule

// File: rtl/fcd_divider.sv
module fcd_divider #(
    parameter int unsigned DIV_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             restart,
    input  logic             step,
    input  logic [DIV_W-1:0] limit,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_q;
    logic             hold;

    assign hold = !run || restart;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    cnt_q <= '0;
        else if (hold) cnt_q <= '0;
        else if (step) cnt_q <= (cnt_q == limit) ? '0 : cnt_q + 1'b1;
    end

    assign tick = run && step && (cnt_q == limit);

    // R7: the count never passes the programmed divisor while running
    a_r7_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt_q <= limit));
endmodule

// File: rtl/flash_tick_gen.sv
module flash_tick_gen #(
    parameter int unsigned DIV_W    = 6,
    parameter int unsigned PRE_LOG2 = 3,
    localparam int unsigned WORD_W  = DIV_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wdata,
    input  logic              test_mode,
    input  logic              flash_done,
    output logic [WORD_W-1:0] rdata,
    output logic              tick,
    output logic              pe_enable
);
    logic             loaded, pre8, restart, pre_tick;
    logic [DIV_W-1:0] divisor;

    fcd_cfg_reg #(.DIV_W(DIV_W)) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_stb     (sel && wr_en),
        .test_mode  (test_mode),
        .flash_done (flash_done),
        .wdata      (wdata),
        .loaded     (loaded),
        .pre8       (pre8),
        .divisor    (divisor),
        .restart    (restart)
    );

    fcd_prescale #(.PRE_LOG2(PRE_LOG2)) u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .hold     (!loaded || restart),
        .enable   (pre8),
        .pre_tick (pre_tick)
    );

    fcd_divider #(.DIV_W(DIV_W)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (loaded),
        .restart (restart),
        .step    (pre_tick),
        .limit   (divisor),
        .tick    (tick)
    );

    assign rdata     = {loaded, pre8, divisor};
    assign pe_enable = loaded;

    // R10: no timing pulse unless the word has been loaded
    a_r10_tick_needs_load: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> pe_enable);
    // R4: a write without sel leaves the read-back word unchanged
    a_r4_sel_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel) |=> $stable(rdata));
endmodule

// File: tb/flash_tick_gen_test.sv
module flash_tick_gen_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sel = 1'b0, wr_en = 1'b0, test_mode = 1'b0, flash_done = 1'b1;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       tick, pe_enable;
    int         checks = 0, errors = 0;
    bit         finished = 1'b0;

    always #5 clk = ~clk;

    flash_tick_gen uut (
        .clk(clk), .rst_n(rst_n), .sel(sel), .wr_en(wr_en), .wdata(wdata),
        .test_mode(test_mode), .flash_done(flash_done),
        .rdata(rdata), .tick(tick), .pe_enable(pe_enable)
    );

    // {prescale, divisor, expected period in bus cycles}
    localparam logic [16:0] VEC [7] = '{
        {1'b0, 6'd0,  10'd1},
        {1'b0, 6'd1,  10'd2},
        {1'b0, 6'd5,  10'd6},
        {1'b0, 6'd49, 10'd50},
        {1'b1, 6'd0,  10'd8},
        {1'b1, 6'd2,  10'd24},
        {1'b1, 6'd12, 10'd104}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // called at a negedge; returns at the negedge of the first cycle after the write edge
    task automatic wr(input logic [7:0] d, input logic tm, input logic dn, input logic s);
        sel = s; wr_en = 1'b1; wdata = d; test_mode = tm; flash_done = dn;
        @(posedge clk);
        @(negedge clk);
        sel = 1'b0; wr_en = 1'b0;
    endtask

    // counts the current cycle as 1 and stops at the cycle carrying tick
    task automatic wait_tick(input int exp, input string req);
        int k = 1;
        while (!tick && k < 2000) begin
            @(negedge clk);
            k++;
        end
        check(k == exp, req, k, exp);
    endtask

    initial begin
        @(negedge clk);
        @(negedge clk);
        check(rdata == 8'h00 && !pe_enable && !tick, "R1", rdata, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        check(rdata == 8'h00 && !pe_enable && !tick, "R1", rdata, 8'h00);

        // first normal-mode write, bit 7 of data is 0
        wr(8'h05, 1'b0, 1'b1, 1'b1);
        check(rdata == 8'h85, "R2", rdata, 8'h85);
        check(pe_enable == 1'b1, "R2", pe_enable, 1);
        wait_tick(6, "R7");
        @(negedge clk);
        wait_tick(6, "R7");

        // ignored write two cycles into a period must not shift the phase
        @(negedge clk);
        @(negedge clk);
        wr(8'h41, 1'b0, 1'b1, 1'b1);
        check(rdata == 8'h85, "R3", rdata, 8'h85);
        wait_tick(4, "R3");

        // write without sel
        wr(8'h3F, 1'b1, 1'b1, 1'b0);
        check(rdata == 8'h85, "R4", rdata, 8'h85);

        // test mode while flash busy
        wr(8'h00, 1'b1, 1'b0, 1'b1);
        check(rdata == 8'h85, "R6", rdata, 8'h85);
        check(rdata == 8'h85, "R11", rdata, 8'h85);

        // test mode clears everything including the flag
        wr(8'h00, 1'b1, 1'b1, 1'b1);
        check(rdata == 8'h00 && !pe_enable, "R5", rdata, 8'h00);
        begin
            int n = 0;
            for (int i = 0; i < 40; i++) begin
                if (tick) n++;
                @(negedge clk);
            end
            check(n == 0, "R10", n, 0);
        end

        // normal-mode write accepted again after the clear
        test_mode = 1'b0;
        wr(8'h02, 1'b0, 1'b1, 1'b1);
        check(rdata == 8'h82, "R10", rdata, 8'h82);
        wait_tick(3, "R10");

        // table of divider settings loaded through test mode
        for (int v = 0; v < 7; v++) begin
            logic [7:0] w;
            string      tag;
            int         per;
            w   = {1'b1, VEC[v][16], VEC[v][15:10]};
            per = int'(VEC[v][9:0]);
            tag = VEC[v][16] ? "R8" : (VEC[v][15:10] == 0 ? "R9" : "R7");
            wr(w, 1'b1, 1'b1, 1'b1);
            check(rdata == w, "R11", rdata, w);
            wait_tick(per, tag);
            @(negedge clk);
            wait_tick(per, tag);
        end

        // a test write with bit 7 set keeps the flag while rewriting fields
        wr(8'hC3, 1'b1, 1'b1, 1'b1);
        check(rdata == 8'hC3 && pe_enable, "R5", rdata, 8'hC3);
        test_mode = 1'b0;

        // reset in mid-run
        rst_n = 1'b0;
        @(negedge clk);
        check(rdata == 8'h00 && !pe_enable && !tick, "R1", rdata, 8'h00);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule